// File: doc/BRIEF.md
# Triple-Lockstep Fault Monitor

This block supervises three processors that execute the same program in lockstep. Each cycle in which a compare-valid strobe is high, it compares the three processor output buses pair by pair. It also watches self-check comparator error flags, a voter error flag and an uncorrectable memory ECC flag. For each category it keeps only the first event it sees, in a read-only 32-bit status word. A single fatal output is raised as soon as any fatal event has been recorded. The word also carries a configuration bit that tells the processors what to do on a sleep instruction: sleep (0) or reset (1).

The detection logic exists twice. A primary copy fills bits 15:0 and a redundant copy fills bits 31:16 with the same layout. The two copies share no state and each has its own comparators. A defect in one detector therefore shows up as a difference between the two halves instead of silently hiding a fault. Only the reset clears the recorded state.

Top module: `lockstep_fault_monitor`

## Requirements
- R1: While `cmpValid` is high, the lockstep field (status bits 2:0) captures the pair mismatches one clock after the edge that samples the buses: bit 0 = A differs from B, bit 1 = A differs from C, bit 2 = B differs from C.
- R2: Only the first lockstep event is kept. All pair bits active in that same cycle are captured together. While the field is nonzero, later mismatches leave it unchanged.
- R3: While `cmpValid` is low, bus differences are ignored and the lockstep field stays unchanged.
- R4: Status bits 13:11 capture the first nonzero value of `selfChkErr` and hold it afterwards. The input bits are ordered as in R1: bit 0 = pair 1-2, bit 1 = pair 1-3, bit 2 = pair 2-3.
- R5: Status bits 10:8 always equal the captured lockstep field (bits 2:0).
- R6: Status bit 14 sets on `voterErr` and bit 15 sets on `eccUncorr`. Both stay set until reset.
- R7: Status bit 3 shows the value of `sleepRstCfg` sampled at the previous clock edge (0 = sleep, 1 = reset the processors).
- R8: Bits 31:16 are produced by an independent second detector with the same layout as bits 15:0. On a fault-free detector the two halves are equal.
- R9: Bits 7:4 and 23:20 always read as zero.
- R10: While `rstN` is low, the whole status word clears to zero on the clock edge and `fatalAny` is low.
- R11: `fatalAny` is high exactly when any bit of 15:8 or 31:24 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmpValid | input | 1 | Bus comparison enabled this cycle |
| busA | input | BUS_W | Output bus of processor 1 |
| busB | input | BUS_W | Output bus of processor 2 |
| busC | input | BUS_W | Output bus of processor 3 |
| selfChkErr | input | 3 | Self-check comparator errors, pair order 1-2, 1-3, 2-3 |
| voterErr | input | 1 | Voter self-check error |
| eccUncorr | input | 1 | Uncorrectable RAM ECC error |
| sleepRstCfg | input | 1 | Sleep-instruction response: 0 sleep, 1 reset |
| faultStatus | output | 32 | Read-only status word |
| fatalAny | output | 1 | Any fatal fault recorded in either half |

## Verification
The bench targets simultaneous pair mismatches in the first fault cycle. A design that latches bit by bit would lose pairs there, or would later add new pairs to an already captured pattern. It also drives bus differences while compare-valid is low, which a design that ignores the gate would record. Self-check, voter and ECC events are pulsed only briefly, which catches registers that follow the input instead of holding it. Every cycle the upper half is compared against the model, so a fault in only the redundant copy is still reported.

// File: rtl/lsfm_pkg.sv
package lsfm_pkg;
  localparam int NUM_CPU   = 3;
  localparam int PAIRS     = 3;
  localparam int HALF_W    = 16;
  localparam int STATUS_W  = 2 * HALF_W;
  localparam int LS_LSB    = 0;
  localparam int SLEEP_BIT = 3;
  localparam int FATAL_LSB = 8;
  localparam int SC_LSB    = FATAL_LSB + PAIRS;
  localparam int VOTER_BIT = SC_LSB + PAIRS;
  localparam int ECC_BIT   = VOTER_BIT + 1;

  typedef struct packed {
    logic             loadLs;
    logic [PAIRS-1:0] lsVal;
    logic             loadSc;
    logic [PAIRS-1:0] scVal;
    logic             setVoter;
    logic             setEcc;
    logic             sleepVal;
  } detStrobeT;
endpackage

// File: rtl/lsfm_ctrl.sv
module lsfm_ctrl
  import lsfm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic [BUS_W-1:0] busA,
  input  logic [BUS_W-1:0] busB,
  input  logic [BUS_W-1:0] busC,
  input  logic             cmpValid,
  input  logic [PAIRS-1:0] selfChkErr,
  input  logic             voterErr,
  input  logic             eccUncorr,
  input  logic             sleepRstCfg,
  input  logic             lsHeld,
  input  logic             scHeld,
  output detStrobeT        strb
);
  logic [BUS_W-1:0] busArr [NUM_CPU];
  logic [PAIRS-1:0] pairDiff;

  assign busArr[0] = busA;
  assign busArr[1] = busB;
  assign busArr[2] = busC;

  // pair p: 0 -> (1,2), 1 -> (1,3), 2 -> (2,3)
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int LO = (p == 2) ? 1 : 0;
    localparam int HI = (p == 0) ? 1 : 2;
    assign pairDiff[p] = cmpValid && (busArr[LO] != busArr[HI]);
  end

  always_comb begin
    strb.loadLs   = !lsHeld && (|pairDiff);
    strb.lsVal    = pairDiff;
    strb.loadSc   = !scHeld && (|selfChkErr);
    strb.scVal    = selfChkErr;
    strb.setVoter = voterErr;
    strb.setEcc   = eccUncorr;
    strb.sleepVal = sleepRstCfg;
  end
endmodule

// File: rtl/lsfm_dp.sv
module lsfm_dp
  import lsfm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  detStrobeT         strb,
  output logic [HALF_W-1:0] half,
  output logic              lsHeld,
  output logic              scHeld
);
  logic [PAIRS-1:0] lsQ;
  logic [PAIRS-1:0] scQ;
  logic             voterQ;
  logic             eccQ;
  logic             sleepQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lsQ    <= '0;
      scQ    <= '0;
      voterQ <= 1'b0;
      eccQ   <= 1'b0;
      sleepQ <= 1'b0;
    end else begin
      if (strb.loadLs) lsQ <= strb.lsVal;
      if (strb.loadSc) scQ <= strb.scVal;
      if (strb.setVoter) voterQ <= 1'b1;
      if (strb.setEcc) eccQ <= 1'b1;
      sleepQ <= strb.sleepVal;
    end
  end

  assign lsHeld = |lsQ;
  assign scHeld = |scQ;

  always_comb begin
    half = '0;
    half[LS_LSB +: PAIRS]    = lsQ;
    half[SLEEP_BIT]          = sleepQ;
    half[FATAL_LSB +: PAIRS] = lsQ;
    half[SC_LSB +: PAIRS]    = scQ;
    half[VOTER_BIT]          = voterQ;
    half[ECC_BIT]            = eccQ;
  end

  a_r2_ls_hold: assert property (@(posedge clk) disable iff (!rstN)
    (lsQ != '0) |=> $stable(lsQ));
  a_r4_sc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (scQ != '0) |=> $stable(scQ));
  a_r6_voter_sticky: assert property (@(posedge clk) disable iff (!rstN)
    voterQ |=> voterQ);
  a_r6_ecc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    eccQ |=> eccQ);
endmodule

// File: rtl/lockstep_fault_monitor.sv
module lockstep_fault_monitor
  import lsfm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmpValid,
  input  logic [BUS_W-1:0]    busA,
  input  logic [BUS_W-1:0]    busB,
  input  logic [BUS_W-1:0]    busC,
  input  logic [PAIRS-1:0]    selfChkErr,
  input  logic                voterErr,
  input  logic                eccUncorr,
  input  logic                sleepRstCfg,
  output logic [STATUS_W-1:0] faultStatus,
  output logic                fatalAny
);
  localparam int COPIES = 2;

  detStrobeT         strbArr [COPIES];
  logic [HALF_W-1:0] halfArr [COPIES];
  logic [COPIES-1:0] lsHeldV;
  logic [COPIES-1:0] scHeldV;

  // copy 0 = primary (low half), copy 1 = redundant (high half)
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    lsfm_ctrl #(.BUS_W(BUS_W)) u_ctrl (
      .busA(busA), .busB(busB), .busC(busC), .cmpValid(cmpValid),
      .selfChkErr(selfChkErr), .voterErr(voterErr), .eccUncorr(eccUncorr),
      .sleepRstCfg(sleepRstCfg), .lsHeld(lsHeldV[c]), .scHeld(scHeldV[c]),
      .strb(strbArr[c])
    );
    lsfm_dp u_dp (
      .clk(clk), .rstN(rstN), .strb(strbArr[c]), .half(halfArr[c]),
      .lsHeld(lsHeldV[c]), .scHeld(scHeldV[c])
    );
    assign faultStatus[c*HALF_W +: HALF_W] = halfArr[c];
  end

  assign fatalAny = (|faultStatus[FATAL_LSB +: 8])
                  | (|faultStatus[HALF_W + FATAL_LSB +: 8]);

  a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpValid && faultStatus[2:0] == '0) |=> (faultStatus[2:0] == '0));
  a_r5_mirror: assert property (@(posedge clk) disable iff (!rstN)
    faultStatus[10:8] == faultStatus[2:0]);
  a_r8_halves_agree: assert property (@(posedge clk) disable iff (!rstN)
    faultStatus[31:16] == faultStatus[15:0]);
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus[7:4] == '0) && (faultStatus[23:20] == '0));
  a_r10_reset: assert property (@(posedge clk)
    !rstN |=> (faultStatus == '0));
  a_r11_fatal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fatalAny |=> fatalAny);
endmodule

// File: tb/sim_lockstep_fault_monitor.sv
module sim_lockstep_fault_monitor;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmpValid = 1'b0;
  logic [BW-1:0] busA = '0, busB = '0, busC = '0;
  logic [2:0]    selfChkErr = '0;
  logic          voterErr = 1'b0, eccUncorr = 1'b0, sleepRstCfg = 1'b0;
  logic [31:0]   faultStatus;
  logic          fatalAny;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  int refLs = 0, refSc = 0, refVoter = 0, refEcc = 0, refSleep = 0;

  lockstep_fault_monitor #(.BUS_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .busA(busA), .busB(busB),
    .busC(busC), .selfChkErr(selfChkErr), .voterErr(voterErr),
    .eccUncorr(eccUncorr), .sleepRstCfg(sleepRstCfg),
    .faultStatus(faultStatus), .fatalAny(fatalAny)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // model update at the edge (inputs only change at negedge)
  always @(posedge clk) begin
    if (!rstN) begin
      refLs = 0; refSc = 0; refVoter = 0; refEcc = 0; refSleep = 0;
    end else begin
      int mm;
      mm = 0;
      if (cmpValid) begin
        if (busA != busB) mm += 1;
        if (busA != busC) mm += 2;
        if (busB != busC) mm += 4;
      end
      if (refLs == 0) refLs = mm;
      if (refSc == 0) refSc = int'(selfChkErr);
      if (voterErr) refVoter = 1;
      if (eccUncorr) refEcc = 1;
      refSleep = int'(sleepRstCfg);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expHalf();
    logic [15:0] h;
    h = '0;
    h[2:0]   = refLs[2:0];
    h[3]     = refSleep[0];
    h[10:8]  = refLs[2:0];
    h[13:11] = refSc[2:0];
    h[14]    = refVoter[0];
    h[15]    = refEcc[0];
    return h;
  endfunction

  // one cycle: compare at negedge, then drive the next inputs
  task automatic step(input logic rst, input logic v, input logic [BW-1:0] a,
                      input logic [BW-1:0] b, input logic [BW-1:0] c,
                      input logic [2:0] sc, input logic vo, input logic ec,
                      input logic sl);
    logic [15:0] h;
    @(negedge clk);
    h = expHalf();
    chk("R1/R2 lockstep field", {29'd0, faultStatus[2:0]}, {29'd0, h[2:0]});
    chk("R5 fatal mismatch copy", {29'd0, faultStatus[10:8]}, {29'd0, h[10:8]});
    chk("R4 self-check field", {29'd0, faultStatus[13:11]}, {29'd0, h[13:11]});
    chk("R6 voter/ecc", {30'd0, faultStatus[15:14]}, {30'd0, h[15:14]});
    chk("R7 sleep response", {31'd0, faultStatus[3]}, {31'd0, h[3]});
    chk("R9 reserved", {24'd0, faultStatus[23:20], faultStatus[7:4]}, 32'd0);
    chk("R8 redundant half", {16'd0, faultStatus[31:16]}, {16'd0, h});
    chk("R11 fatal output", {31'd0, fatalAny}, {31'd0, (|h[15:8])});
    rstN = rst; cmpValid = v; busA = a; busB = b; busC = c;
    selfChkErr = sc; voterErr = vo; eccUncorr = ec; sleepRstCfg = sl;
  endtask

  task automatic doReset();
    step(1'b0, 0, '0, '0, '0, 3'b0, 0, 0, 0);
    step(1'b0, 0, '0, '0, '0, 3'b0, 0, 0, 0);
    step(1'b1, 0, '0, '0, '0, 3'b0, 0, 0, 0);
    chk("R10 reset word", faultStatus, 32'd0);
    chk("R10 reset fatal", {31'd0, fatalAny}, 32'd0);
  endtask

  initial begin
    logic [BW-1:0] x;
    doReset();
    // clean lockstep, sleep config toggling (R7)
    for (int i = 0; i < 6; i++) begin
      x = 32'h1000_0000 + i;
      step(1'b1, 1, x, x, x, 3'b0, 0, 0, logic'(i[0]));
    end
    // R3: differences while compare-valid low are ignored
    step(1'b1, 0, 32'hAAAA, 32'h5555, 32'h0F0F, 3'b0, 0, 0, 0);
    step(1'b1, 0, 32'h1, 32'h2, 32'h1, 3'b0, 0, 0, 1);
    step(1'b1, 1, 32'h7, 32'h7, 32'h7, 3'b0, 0, 0, 1);
    chk("R3 gated compare", {29'd0, faultStatus[2:0]}, 32'd0);
    // R1/R2: C deviates -> pairs 1-3 and 2-3 together (110b)
    step(1'b1, 1, 32'h9, 32'h9, 32'h8, 3'b0, 0, 0, 1);
    step(1'b1, 1, 32'h1, 32'h2, 32'h2, 3'b0, 0, 0, 1);
    step(1'b1, 1, 32'h1, 32'h1, 32'h1, 3'b0, 0, 0, 1);
    chk("R2 first pattern kept", {29'd0, faultStatus[2:0]}, 32'd6);
    chk("R11 fatal after mismatch", {31'd0, fatalAny}, 32'd1);
    doReset();
    // R1: single-pair mismatch A vs B is not possible alone; B deviates -> 101b
    step(1'b1, 1, 32'h3, 32'h4, 32'h3, 3'b0, 0, 0, 0);
    step(1'b1, 1, 32'h3, 32'h3, 32'h3, 3'b0, 0, 0, 0);
    chk("R1 pair order B deviates", {29'd0, faultStatus[2:0]}, 32'd5);
    doReset();
    // R4: first self-check value held; R6: pulses stick
    step(1'b1, 0, '0, '0, '0, 3'b010, 0, 0, 0);
    step(1'b1, 0, '0, '0, '0, 3'b101, 1, 0, 0);
    step(1'b1, 0, '0, '0, '0, 3'b000, 0, 1, 0);
    step(1'b1, 0, '0, '0, '0, 3'b000, 0, 0, 0);
    chk("R4 self-check held", {29'd0, faultStatus[13:11]}, 32'd2);
    chk("R6 sticky bits", {30'd0, faultStatus[15:14]}, 32'd3);
    chk("R11 fatal from self-check", {31'd0, fatalAny}, 32'd1);
    // pseudo-random traffic with periodic resets
    for (int i = 0; i < 600; i++) begin
      logic [BW-1:0] a, b, c;
      int r;
      a = $urandom; b = a; c = a; r = $urandom % 10;
      if (r == 1) b = a ^ (32'h1 << ($urandom % 32));
      if (r == 2) c = a ^ (32'h1 << ($urandom % 32));
      if (r == 3) a = ~a;
      if (r == 4) begin b = a + 1; c = a + 2; end
      step((i % 60) != 59, ($urandom % 4) != 0, a, b, c,
           (($urandom % 12) == 0) ? 3'($urandom) : 3'b0,
           ($urandom % 40) == 0, ($urandom % 40) == 0, 1'($urandom));
    end
    step(1'b1, 0, '0, '0, '0, 3'b0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule